// File: doc/BRIEF.md
# Length-Steered Serial Register Loader

This block is a three-wire serial slave that fills one of three holding registers from a stream of bits. A host pulls the active-low enable down, presents bits most significant first on the data line with one rising edge of the serial clock per bit, and then releases the enable. The frame carries no address or steering field. The block counts the clock edges it received in the enable window and picks the target from that count: 8 bits fill the configuration register, 16 bits fill the reference register, and 24 bits fill the main register. Any other count leaves every register as it was.

The reference register is split. Its top 3 bits take effect as soon as a 16-bit frame commits. Its low 13 bits land first in a staging copy and reach the live copy only when a 24-bit main frame commits, or when the host drops and raises the enable with no clock edge in between. The host can therefore stage a new reference value and have it appear in the same cycle as a new main value. A serial data-out line presents the bit leaving the far end of the shift chain and changes on falling clock edges.

The serial clock, enable and data pins are asynchronous to the system clock. The block resynchronises them and finds the edges from the resynchronised copies. The serial link has no back-pressure: the host sets the pace, and the block accepts each bit on the cycle that its rising edge is detected. All register contents are exposed as parallel outputs.

Top module: `serial_len_loader`

## Requirements
- R1: Bits are captured on rising serial clock edges, most significant bit first. The first bit of a frame lands in the highest bit of the target register.
- R2: A frame of exactly 8 rising edges writes `cfg_o` with the 8 bits received.
- R3: A frame of exactly 16 rising edges works as follows. Received bits [15:13] go to `ref_imm_o`. Received bits [12:0] go to `ref_stage_o`. `ref_live_o` stays unchanged.
- R4: A frame of exactly 24 rising edges writes `main_o` with the 24 bits received. In the same cycle it copies `ref_stage_o` into `ref_live_o`.
- R5: A frame whose edge count is not 0, 8, 16 or 24 changes no register. This includes counts such as 7, 12 and 31.
- R6: No register output changes while a frame is being shifted in. A register is written only when the synchronised enable returns high.
- R7: An enable low window with no rising clock edge copies `ref_stage_o` into `ref_live_o` and leaves every other register alone.
- R8: `ser_dout_o` changes only on a detected falling serial clock edge while enable is low. After the k-th falling edge it shows the bit received k-23 bits earlier in the frame (bit k-23, counting the first bit as 1) when k >= 24, and 0 otherwise.
- R9: After reset every register output and `ser_dout_o` are 0.
- R10: The edge counter saturates at 32. Frames of 40 or 48 edges are never taken as a legal length and change no register.
- R11: `ser_dout_o` is 0 whenever the synchronised enable is high.
- R12: While enable is high, serial clock edges neither shift nor count. A following frame is judged only on the edges inside its own window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_en_n_i | input | 1 | Active-low frame enable, asynchronous |
| ser_din_i | input | 1 | Serial data in |
| ser_dout_o | output | 1 | Serial data out from the end of the shift chain |
| cfg_o | output | 8 | Configuration register |
| ref_imm_o | output | 3 | Immediate upper bits of the reference register |
| ref_stage_o | output | 13 | Staging copy of the reference low bits |
| ref_live_o | output | 13 | Live copy of the reference low bits |
| main_o | output | 24 | Main register |

## Verification
On every cycle the assertions check four things. The registers hold still unless the enable has just risen. A 16-bit commit leaves the live reference copy alone, and a 24-bit or empty commit loads that copy from the stage. The data-out line moves only on a falling-edge strobe and sits low while enable is high. The counter stays pinned at its limit. The bench scenarios are needed for everything else: the length-to-register mapping and bit order, rejection of specific illegal and over-long lengths, that stray clocks outside the window are ignored, and the exact bit that appears on data-out after each falling edge.

// File: rtl/sll_pkg.sv
package sll_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_CFG  = 3'd1,
    TGT_REF  = 3'd2,
    TGT_MAIN = 3'd3,
    TGT_XFER = 3'd4
  } sll_target_e;

  localparam int SIG_CLK  = 0;
  localparam int SIG_EN_N = 1;
  localparam int SIG_DIN  = 2;
  localparam int SIG_NUM  = 3;
endpackage

// File: rtl/sll_sync.sv
module sll_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= async_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= RST_VAL;
    else prev_q <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/sll_shifter.sv
module sll_shifter #(
  parameter int SHIFT_W = 24,
  parameter int CNT_SAT = 32,
  localparam int CNT_W  = $clog2(CNT_SAT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_i,
  input  logic               shift_stb_i,
  input  logic               drop_stb_i,
  input  logic               din_i,
  output logic [SHIFT_W-1:0] shreg_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               dout_o
);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(CNT_SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_o <= '0;
      cnt_o   <= '0;
      dout_o  <= 1'b0;
    end else if (idle_i) begin
      shreg_o <= '0;
      cnt_o   <= '0;
      dout_o  <= 1'b0;
    end else begin
      if (shift_stb_i) begin
        shreg_o <= {shreg_o[SHIFT_W-2:0], din_i};
        if (cnt_o != SAT_VAL) cnt_o <= cnt_o + 1'b1;
      end
      if (drop_stb_i) dout_o <= shreg_o[SHIFT_W-1];
    end
  end

  AST_CNT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == SAT_VAL && !idle_i) |=> (cnt_o == SAT_VAL || idle_i)); // R10
  AST_DOUT_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!drop_stb_i && !idle_i) |=> $stable(dout_o)); // R8
  AST_DOUT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (dout_o == 1'b0)); // R11
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (cnt_o == '0)); // R12
endmodule

// File: rtl/sll_regfile.sv
module sll_regfile
  import sll_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int REF_W    = 16,
  parameter int REF_DB_W = 13,
  parameter int MAIN_W   = 24,
  parameter int CNT_SAT  = 32,
  localparam int CNT_W   = $clog2(CNT_SAT + 1),
  localparam int IMM_W   = REF_W - REF_DB_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [MAIN_W-1:0]   shreg_i,
  output logic [CFG_W-1:0]    cfg_o,
  output logic [IMM_W-1:0]    ref_imm_o,
  output logic [REF_DB_W-1:0] ref_stage_o,
  output logic [REF_DB_W-1:0] ref_live_o,
  output logic [MAIN_W-1:0]   main_o
);
  sll_target_e tgt;

  always_comb begin
    if (cnt_i == CNT_W'(CFG_W))       tgt = TGT_CFG;
    else if (cnt_i == CNT_W'(REF_W))  tgt = TGT_REF;
    else if (cnt_i == CNT_W'(MAIN_W)) tgt = TGT_MAIN;
    else if (cnt_i == '0)             tgt = TGT_XFER;
    else                              tgt = TGT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o       <= '0;
      ref_imm_o   <= '0;
      ref_stage_o <= '0;
      ref_live_o  <= '0;
      main_o      <= '0;
    end else if (commit_i) begin
      unique case (tgt)
        TGT_CFG:  cfg_o <= shreg_i[CFG_W-1:0];
        TGT_REF: begin
          ref_imm_o   <= shreg_i[REF_W-1:REF_DB_W];
          ref_stage_o <= shreg_i[REF_DB_W-1:0];
        end
        TGT_MAIN: begin
          main_o     <= shreg_i;
          ref_live_o <= ref_stage_o;
        end
        TGT_XFER: ref_live_o <= ref_stage_o;
        default: ;
      endcase
    end
  end

  AST_HOLD_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(cfg_o) && $stable(ref_imm_o) && $stable(ref_stage_o)
                   && $stable(ref_live_o) && $stable(main_o))); // R6
  AST_REF_LIVE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && cnt_i == CNT_W'(REF_W)) |=> $stable(ref_live_o)); // R3
  AST_MAIN_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && cnt_i == CNT_W'(MAIN_W)) |=> (ref_live_o == $past(ref_stage_o))); // R4
  AST_EMPTY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && cnt_i == '0) |=> (ref_live_o == $past(ref_stage_o) && $stable(main_o))); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && tgt == TGT_NONE) |=> ($stable(cfg_o) && $stable(main_o)
                                       && $stable(ref_stage_o) && $stable(ref_live_o))); // R5
endmodule

// File: rtl/serial_len_loader.sv
module serial_len_loader
  import sll_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int REF_W       = 16,
  parameter int REF_DB_W    = 13,
  parameter int MAIN_W      = 24,
  parameter int CNT_SAT     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IMM_W      = REF_W - REF_DB_W,
  localparam int CNT_W      = $clog2(CNT_SAT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk_i,
  input  logic                ser_en_n_i,
  input  logic                ser_din_i,
  output logic                ser_dout_o,
  output logic [CFG_W-1:0]    cfg_o,
  output logic [IMM_W-1:0]    ref_imm_o,
  output logic [REF_DB_W-1:0] ref_stage_o,
  output logic [REF_DB_W-1:0] ref_live_o,
  output logic [MAIN_W-1:0]   main_o
);
  localparam logic [SIG_NUM-1:0] SYNC_RST = SIG_NUM'(1) << SIG_EN_N;

  logic [SIG_NUM-1:0] pins, lvl, rise, fall;
  logic [MAIN_W-1:0]  shreg;
  logic [CNT_W-1:0]   cnt;

  always_comb begin
    pins           = '0;
    pins[SIG_CLK]  = ser_clk_i;
    pins[SIG_EN_N] = ser_en_n_i;
    pins[SIG_DIN]  = ser_din_i;
  end

  sll_sync #(.N(SIG_NUM), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  sll_shifter #(.SHIFT_W(MAIN_W), .CNT_SAT(CNT_SAT)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .idle_i(lvl[SIG_EN_N]),
    .shift_stb_i(rise[SIG_CLK]),
    .drop_stb_i(fall[SIG_CLK]),
    .din_i(lvl[SIG_DIN]),
    .shreg_o(shreg), .cnt_o(cnt), .dout_o(ser_dout_o)
  );

  sll_regfile #(.CFG_W(CFG_W), .REF_W(REF_W), .REF_DB_W(REF_DB_W),
                .MAIN_W(MAIN_W), .CNT_SAT(CNT_SAT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_i(rise[SIG_EN_N]), .cnt_i(cnt), .shreg_i(shreg),
    .cfg_o(cfg_o), .ref_imm_o(ref_imm_o), .ref_stage_o(ref_stage_o),
    .ref_live_o(ref_live_o), .main_o(main_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (cfg_o == '0 && main_o == '0 && ref_live_o == '0 && ser_dout_o == 1'b0)); // R9
endmodule

// File: tb/tb_serial_len_loader.sv
module tb_serial_len_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_en_n = 1'b1, ser_din = 1'b0;
  logic ser_dout;
  logic [7:0]  cfg;
  logic [2:0]  ref_imm;
  logic [12:0] ref_stage, ref_live;
  logic [23:0] main_r;

  always #5 clk = ~clk;

  serial_len_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_en_n_i(ser_en_n),
    .ser_din_i(ser_din), .ser_dout_o(ser_dout), .cfg_o(cfg), .ref_imm_o(ref_imm),
    .ref_stage_o(ref_stage), .ref_live_o(ref_live), .main_o(main_r)
  );

  typedef struct {
    string       req;
    logic [7:0]  cfg;
    logic [2:0]  imm;
    logic [12:0] stage;
    logic [12:0] live;
    logic [23:0] main;
  } exp_t;

  exp_t model;
  exp_t q[$];
  event frame_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input string req, input logic [63:0] bits, input int n,
                            input bit chk_dout);
    logic exp_do = 1'b0;
    ser_en_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      ser_din = bits[n-1-i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(5);
      if (chk_dout) chk("R8 dout held across rising edge", 32'(ser_dout), 32'(exp_do));
      ser_clk = 1'b0;
      wait_clk(5);
      if (chk_dout) begin
        exp_do = (i + 1 >= 24) ? bits[n-1-(i+1-24)] : 1'b0;
        chk("R8 dout after falling edge", 32'(ser_dout), 32'(exp_do));
      end
    end
    if (n > 0) begin
      chk("R6 cfg held mid-frame", 32'(cfg), 32'(model.cfg));
      chk("R6 main held mid-frame", 32'(main_r), 32'(model.main));
    end
    ser_en_n = 1'b1;
    wait_clk(8);
    if (n == 8) model.cfg = bits[7:0];
    else if (n == 16) begin
      model.imm   = bits[15:13];
      model.stage = bits[12:0];
    end else if (n == 24) begin
      model.main = bits[23:0];
      model.live = model.stage;
    end else if (n == 0) model.live = model.stage;
    model.req = req;
    q.push_back(model);
    ->frame_done;
    wait_clk(2);
  endtask

  initial begin : monitor
    forever begin
      @frame_done;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.req, " cfg"},   32'(cfg),       32'(e.cfg));
        chk({e.req, " imm"},   32'(ref_imm),   32'(e.imm));
        chk({e.req, " stage"}, 32'(ref_stage), 32'(e.stage));
        chk({e.req, " live"},  32'(ref_live),  32'(e.live));
        chk({e.req, " main"},  32'(main_r),    32'(e.main));
        chk("R11 dout low when idle", 32'(ser_dout), 32'(0));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    model = '{req: "", cfg: '0, imm: '0, stage: '0, live: '0, main: '0};
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R9 reset cfg", 32'(cfg), 32'(0));
    chk("R9 reset main", 32'(main_r), 32'(0));
    chk("R9 reset live", 32'(ref_live), 32'(0));
    chk("R9 reset stage", 32'(ref_stage), 32'(0));
    chk("R9 reset dout", 32'(ser_dout), 32'(0));

    send_frame("R1 R2 cfg frame", 64'hA5, 8, 0);
    send_frame("R3 ref frame", 64'hE123, 16, 0);
    send_frame("R4 main frame", 64'h5A3C96, 24, 1);
    send_frame("R3 second ref frame", 64'h2ABC, 16, 0);
    send_frame("R7 empty pulse", 64'h0, 0, 0);
    send_frame("R5 seven bits", 64'h7F, 7, 0);
    send_frame("R5 twelve bits", 64'hFFF, 12, 0);
    send_frame("R5 thirty-one bits", 64'h7FFF_FFFF, 31, 0);
    send_frame("R10 forty bits", 64'hB5_0000_00C3, 40, 1);
    send_frame("R10 forty-eight bits", 64'hFFFF_1234_5618, 48, 0);

    for (int i = 0; i < 8; i++) begin
      wait_clk(4); ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0;
    end
    send_frame("R12 cfg after idle clocks", 64'h3C, 8, 0);
    send_frame("R4 second main frame", 64'h81_0F0F, 24, 0);

    wait_clk(5);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule